// File: doc/BRIEF.md
# Upward-Growing Hardware Stack Pointer

This block keeps an 8-bit stack pointer and turns stack requests into accesses to a 256-byte internal data RAM that sits inside the block. A single-byte push raises the pointer first and then stores the byte at the new pointer value. A single-byte pop reads the byte at the current pointer and then lowers the pointer. The pointer is also a special function register at address 0x81, so software can read it and load it. After reset the pointer holds 0x07, which places the first stored byte at 0x08.

Subroutine linkage is handled as two-step sequences. A call saves a 16-bit return address as two pushes, low byte first. A return restores that address as two pops, high byte first. The request that starts a sequence is accepted in one cycle. While the second step is pending the block reports busy and takes no new requests. The RAM address, write enable and write data are brought out as ports so that the integration can observe them.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads 0x07, and busy, pop_valid and ret_valid are all 0.
- R2: A push request raises ram_we in the same cycle, with ram_addr equal to the pointer plus 1 and ram_wdata equal to push_data. After that clock edge the pointer has gone up by 1.
- R3: A pop request reads the RAM at the current pointer with ram_we low. One cycle later pop_valid is 1 for a single cycle, pop_data holds the byte that was read, and the pointer has gone down by 1.
- R4: The pointer wraps modulo 256. A push from 0xFF writes address 0x00 and leaves the pointer at 0x00. A pop from 0x00 leaves the pointer at 0xFF.
- R5: When sfr_addr is 0x81, sfr_rdata shows the pointer in the same cycle. For any other address, sfr_rdata is 0.
- R6: A write with sfr_wr=1 and sfr_addr=0x81 loads sfr_wdata into the pointer. In that cycle any push, pop, call or return request is dropped: no RAM write, no valid pulse, no change of state. A write to any other address leaves the pointer unchanged.
- R7: A call takes two cycles. The first cycle writes call_pc[7:0] at pointer+1. The second cycle, with busy=1, writes call_pc[15:8] at pointer+2. The pointer then rises by 2.
- R8: A return takes two cycles. The first pop supplies ret_pc[15:8] and the second pop supplies ret_pc[7:0]. ret_valid is 1 for one cycle after the second pop, and the pointer falls by 2.
- R9: While busy is 1, push, pop, call and return requests are ignored.
- R10: When the block is idle and several requests arrive together, call wins over return, return over push, and push over pop.
- R11: A pointer write that lands on the second step of a call or return holds that step back by one cycle. The step then uses the newly loaded pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| push_req | input | 1 | Push one byte |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Pop one byte |
| pop_data | output | 8 | Last byte popped |
| pop_valid | output | 1 | One-cycle pulse when pop_data has been updated |
| call_req | input | 1 | Start a two-byte save of call_pc |
| call_pc | input | 16 | Return address to save |
| ret_req | input | 1 | Start a two-byte restore |
| ret_pc | output | 16 | Restored return address |
| ret_valid | output | 1 | One-cycle pulse when ret_pc has been updated |
| busy | output | 1 | Second step of a call or return is pending |
| sfr_addr | input | 8 | Special function register address |
| sfr_wr | input | 1 | Special function register write strobe |
| sfr_wdata | input | 8 | Special function register write data |
| sfr_rdata | output | 8 | Pointer value when sfr_addr is 0x81, otherwise 0 |
| ram_addr | output | 8 | Internal RAM address |
| ram_we | output | 1 | Internal RAM write enable |
| ram_wdata | output | 8 | Internal RAM write data |

## Verification
The hardest situation to reach from the ports is a pointer load that falls exactly on the pending second step of a call or return, because it has to hit the single cycle in which busy is high. The bench reaches it by starting the sequence, waiting one cycle, and driving the load on the cycle where busy is known to be high. It then checks which address the delayed step used. Wrap-around is reached by loading the pointer through its register write port, and the bench sweeps every start value with a push and pop round trip. Deeply nested calls and returns are compared against an arithmetic model of the memory.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stk_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CALL = 2'd1,
    SQ_RET  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter int          AW      = 8,
  parameter logic [AW-1:0] RST_VAL = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_op_e       op,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we
);
  logic [AW-1:0] sp_q, sp_d, sp_inc, sp_dec;

  assign sp_inc = sp_q + AW'(1);
  assign sp_dec = sp_q - AW'(1);

  always_comb begin
    sp_d     = sp_q;
    ram_addr = sp_q;
    ram_we   = 1'b0;
    if (load) begin
      sp_d = load_val;
    end else begin
      case (op)
        OP_PUSH: begin
          sp_d     = sp_inc;
          ram_addr = sp_inc;
          ram_we   = 1'b1;
        end
        OP_POP: begin
          sp_d     = sp_dec;
          ram_addr = sp_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= RST_VAL;
    end else begin
      sp_q <= sp_d;
    end
  end

  assign sp = sp_q;

  a_r2_push_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && !load) |=> sp_q == $past(sp_q) + AW'(1));
  a_r3_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && !load) |=> sp_q == $past(sp_q) - AW'(1));
  a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sp_q == $past(load_val));
  a_r6_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !ram_we);
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            push_req,
  input  logic [DW-1:0]   push_data,
  input  logic            pop_req,
  input  logic            call_req,
  input  logic [2*DW-1:0] call_pc,
  input  logic            ret_req,
  input  logic [DW-1:0]   rd_data,
  output stk_op_e         op,
  output logic [DW-1:0]   wdata,
  output logic            busy,
  output logic [DW-1:0]   pop_data,
  output logic            pop_valid,
  output logic [2*DW-1:0] ret_pc,
  output logic            ret_valid
);
  seq_st_e         st_q, st_d;
  logic [DW-1:0]   hi_q, hi_d;
  logic [DW-1:0]   pdat_q, pdat_d;
  logic            pval_q, pval_d;
  logic [2*DW-1:0] rpc_q, rpc_d;
  logic            rval_q, rval_d;

  always_comb begin
    st_d   = st_q;
    hi_d   = hi_q;
    pdat_d = pdat_q;
    pval_d = 1'b0;
    rpc_d  = rpc_q;
    rval_d = 1'b0;
    op     = OP_NONE;
    wdata  = push_data;
    if (!hold) begin
      case (st_q)
        SQ_IDLE: begin
          if (call_req) begin
            op    = OP_PUSH;
            wdata = call_pc[DW-1:0];
            hi_d  = call_pc[2*DW-1:DW];
            st_d  = SQ_CALL;
          end else if (ret_req) begin
            op   = OP_POP;
            hi_d = rd_data;
            st_d = SQ_RET;
          end else if (push_req) begin
            op = OP_PUSH;
          end else if (pop_req) begin
            op     = OP_POP;
            pdat_d = rd_data;
            pval_d = 1'b1;
          end
        end
        SQ_CALL: begin
          op    = OP_PUSH;
          wdata = hi_q;
          st_d  = SQ_IDLE;
        end
        SQ_RET: begin
          op     = OP_POP;
          rpc_d  = {hi_q, rd_data};
          rval_d = 1'b1;
          st_d   = SQ_IDLE;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      hi_q   <= '0;
      pdat_q <= '0;
      pval_q <= 1'b0;
      rpc_q  <= '0;
      rval_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hi_q   <= hi_d;
      pdat_q <= pdat_d;
      pval_q <= pval_d;
      rpc_q  <= rpc_d;
      rval_q <= rval_d;
    end
  end

  assign busy      = (st_q != SQ_IDLE);
  assign pop_data  = pdat_q;
  assign pop_valid = pval_q;
  assign ret_pc    = rpc_q;
  assign ret_valid = rval_q;

  a_r3_valid_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pval_q |-> $past(op == OP_POP));
  a_r8_ret_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    rval_q |-> ($past(op == OP_POP) && $past(st_q == SQ_RET)));
  a_r9_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hold) |=> !busy);
  a_r11_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hold) |=> (busy && $stable(st_q)));
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import stk_pkg::*;
#(
  parameter int         AW       = 8,
  parameter int         DW       = 8,
  parameter logic [7:0] SFR_ADDR = 8'h81,
  parameter logic [AW-1:0] SP_RST = 8'h07
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_req,
  input  logic [DW-1:0]   push_data,
  input  logic            pop_req,
  output logic [DW-1:0]   pop_data,
  output logic            pop_valid,
  input  logic            call_req,
  input  logic [2*DW-1:0] call_pc,
  input  logic            ret_req,
  output logic [2*DW-1:0] ret_pc,
  output logic            ret_valid,
  output logic            busy,
  input  logic [7:0]      sfr_addr,
  input  logic            sfr_wr,
  input  logic [AW-1:0]   sfr_wdata,
  output logic [AW-1:0]   sfr_rdata,
  output logic [AW-1:0]   ram_addr,
  output logic            ram_we,
  output logic [DW-1:0]   ram_wdata
);
  logic          rs_meta_q, rs_sync_q;
  logic          sfr_hit;
  stk_op_e       op;
  logic [AW-1:0] sp;
  logic [DW-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_sync_q <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_sync_q <= rs_meta_q;
    end
  end

  assign sfr_hit   = sfr_wr && (sfr_addr == SFR_ADDR);
  assign sfr_rdata = (sfr_addr == SFR_ADDR) ? sp : '0;

  stk_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rs_sync_q),
    .hold      (sfr_hit),
    .push_req  (push_req),
    .push_data (push_data),
    .pop_req   (pop_req),
    .call_req  (call_req),
    .call_pc   (call_pc),
    .ret_req   (ret_req),
    .rd_data   (rd_data),
    .op        (op),
    .wdata     (ram_wdata),
    .busy      (busy),
    .pop_data  (pop_data),
    .pop_valid (pop_valid),
    .ret_pc    (ret_pc),
    .ret_valid (ret_valid)
  );

  stk_ptr #(.AW(AW), .RST_VAL(SP_RST)) u_ptr (
    .clk      (clk),
    .rst_n    (rs_sync_q),
    .op       (op),
    .load     (sfr_hit),
    .load_val (sfr_wdata),
    .sp       (sp),
    .ram_addr (ram_addr),
    .ram_we   (ram_we)
  );

  stk_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (rd_data)
  );

  a_r7_busy_writes: assert property (@(posedge clk) disable iff (!rs_sync_q)
    (busy && !sfr_hit && $past(ram_we)) |-> ram_we);
  a_r7_second_addr: assert property (@(posedge clk) disable iff (!rs_sync_q)
    (busy && !sfr_hit && $past(ram_we)) |-> ram_addr == $past(ram_addr) + AW'(1));
endmodule

// File: tb/stack_ptr_unit_tb.sv
module stack_ptr_unit_tb;
  localparam int PERIOD = 10;

  logic        clk, rst_n;
  logic        push_req, pop_req, call_req, ret_req, sfr_wr;
  logic [7:0]  push_data, sfr_addr, sfr_wdata;
  logic [15:0] call_pc;
  logic [7:0]  pop_data, sfr_rdata, ram_addr, ram_wdata;
  logic        pop_valid, ret_valid, busy, ram_we;
  logic [15:0] ret_pc;

  int total = 0;
  int bad   = 0;
  bit ended = 0;
  logic [7:0] mem_m [256];
  logic [7:0] sp_m;

  stack_ptr_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .push_req(push_req), .push_data(push_data),
    .pop_req(pop_req), .pop_data(pop_data), .pop_valid(pop_valid),
    .call_req(call_req), .call_pc(call_pc),
    .ret_req(ret_req), .ret_pc(ret_pc), .ret_valid(ret_valid),
    .busy(busy),
    .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic idle_inputs();
    push_req = 0; pop_req = 0; call_req = 0; ret_req = 0; sfr_wr = 0;
    sfr_addr = 8'h81; push_data = 0; call_pc = 0; sfr_wdata = 0;
  endtask

  task automatic do_push(input logic [7:0] b);
    @(negedge clk);
    push_req = 1; push_data = b;
    #1;
    chk(ram_we && ram_addr == sp_m + 8'd1 && ram_wdata == b, "R2 push write",
        {ram_we, ram_addr, ram_wdata}, {1'b1, sp_m + 8'd1, b});
    @(negedge clk);
    push_req = 0;
    sp_m = sp_m + 8'd1;
    mem_m[sp_m] = b;
    chk(sfr_rdata == sp_m, "R2 ptr after push", sfr_rdata, sp_m);
  endtask

  task automatic do_pop();
    @(negedge clk);
    pop_req = 1;
    #1;
    chk(!ram_we && ram_addr == sp_m, "R3 pop read addr", ram_addr, sp_m);
    @(negedge clk);
    pop_req = 0;
    chk(pop_valid && pop_data == mem_m[sp_m], "R3 pop data", pop_data, mem_m[sp_m]);
    sp_m = sp_m - 8'd1;
    chk(sfr_rdata == sp_m, "R3 ptr after pop", sfr_rdata, sp_m);
  endtask

  task automatic set_sp(input logic [7:0] v);
    @(negedge clk);
    sfr_wr = 1; sfr_wdata = v;
    @(negedge clk);
    sfr_wr = 0;
    sp_m = v;
  endtask

  task automatic do_call(input logic [15:0] pc, input bit poke);
    @(negedge clk);
    call_req = 1; call_pc = pc;
    #1;
    chk(ram_we && ram_addr == sp_m + 8'd1 && ram_wdata == pc[7:0], "R7 call low byte",
        ram_wdata, pc[7:0]);
    @(negedge clk);
    call_req = 0;
    if (poke) push_req = 1;
    #1;
    chk(busy && ram_we && ram_addr == sp_m + 8'd2 && ram_wdata == pc[15:8],
        "R7 call high byte", ram_addr, sp_m + 8'd2);
    @(negedge clk);
    push_req = 0;
    mem_m[sp_m + 8'd1] = pc[7:0];
    mem_m[sp_m + 8'd2] = pc[15:8];
    sp_m = sp_m + 8'd2;
    chk(!busy && sfr_rdata == sp_m, "R9 ptr after call, busy ignored", sfr_rdata, sp_m);
  endtask

  task automatic do_ret(input logic [15:0] exp_pc);
    @(negedge clk);
    ret_req = 1;
    @(negedge clk);
    ret_req = 0;
    chk(busy && !ret_valid, "R8 return pending", busy, 1);
    @(negedge clk);
    sp_m = sp_m - 8'd2;
    chk(ret_valid && ret_pc == exp_pc, "R8 return address", ret_pc, exp_pc);
    chk(sfr_rdata == sp_m, "R8 ptr after return", sfr_rdata, sp_m);
  endtask

  initial begin
    #(PERIOD * 200000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    sp_m  = 8'h07;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(sfr_rdata == 8'h07, "R1 reset ptr", sfr_rdata, 8'h07);
    chk(!busy && !pop_valid && !ret_valid, "R1 reset flags", {busy, pop_valid, ret_valid}, 0);

    // R5 read at another address gives zero
    sfr_addr = 8'h80; #1;
    chk(sfr_rdata == 0, "R5 other address", sfr_rdata, 0);
    sfr_addr = 8'h81; #1;
    chk(sfr_rdata == 8'h07, "R5 pointer address", sfr_rdata, 8'h07);

    // R2/R3 first push lands at 0x08
    do_push(8'hA5);
    do_pop();

    // R4 sweep every start value with push and pop round trip
    for (int v = 0; v < 256; v++) begin
      set_sp(8'(v));
      do_push(8'(v ^ 8'h3C));
      do_pop();
    end
    set_sp(8'hFF);
    do_push(8'h11);
    chk(sfr_rdata == 8'h00, "R4 wrap up", sfr_rdata, 0);
    do_pop();
    chk(sfr_rdata == 8'hFF, "R4 wrap down", sfr_rdata, 8'hFF);

    // R6 write wins over push in same cycle
    set_sp(8'h40);
    @(negedge clk);
    sfr_wr = 1; sfr_wdata = 8'h90; push_req = 1; push_data = 8'hEE;
    #1;
    chk(!ram_we, "R6 push dropped", ram_we, 0);
    @(negedge clk);
    sfr_wr = 0; push_req = 0;
    sp_m = 8'h90;
    chk(sfr_rdata == 8'h90 && !pop_valid, "R6 load value", sfr_rdata, 8'h90);
    // R6 write to another address has no effect
    @(negedge clk);
    sfr_addr = 8'h80; sfr_wr = 1; sfr_wdata = 8'h12;
    @(negedge clk);
    sfr_wr = 0; sfr_addr = 8'h81; #1;
    chk(sfr_rdata == 8'h90, "R6 other address write", sfr_rdata, 8'h90);

    // R10 priority: call beats push/pop/return
    @(negedge clk);
    call_req = 1; ret_req = 1; push_req = 1; pop_req = 1; call_pc = 16'hBEEF; push_data = 8'h55;
    #1;
    chk(ram_we && ram_wdata == 8'hEF, "R10 call first", ram_wdata, 8'hEF);
    @(negedge clk);
    call_req = 0; ret_req = 0; push_req = 0; pop_req = 0;
    @(negedge clk);
    mem_m[sp_m + 8'd1] = 8'hEF; mem_m[sp_m + 8'd2] = 8'hBE; sp_m = sp_m + 8'd2;
    chk(sfr_rdata == sp_m, "R10 ptr after call", sfr_rdata, sp_m);
    // R10 push beats pop
    @(negedge clk);
    push_req = 1; pop_req = 1; push_data = 8'h66;
    #1;
    chk(ram_we && ram_wdata == 8'h66, "R10 push over pop", ram_wdata, 8'h66);
    @(negedge clk);
    push_req = 0; pop_req = 0;
    sp_m = sp_m + 8'd1; mem_m[sp_m] = 8'h66;
    do_pop();
    // R10 return beats push
    @(negedge clk);
    ret_req = 1; push_req = 1;
    #1;
    chk(!ram_we, "R10 return over push", ram_we, 0);
    @(negedge clk);
    ret_req = 0; push_req = 0;
    @(negedge clk);
    sp_m = sp_m - 8'd2;
    chk(ret_valid && ret_pc == 16'hBEEF, "R10 return value", ret_pc, 16'hBEEF);

    // R7/R8/R9 nested calls and returns
    set_sp(8'h07);
    for (int d = 0; d < 20; d++) do_call(16'(16'h1000 + d * 16'h0131), d[0]);
    for (int d = 19; d >= 0; d--) do_ret(16'(16'h1000 + d * 16'h0131));
    chk(sfr_rdata == 8'h07, "R8 nested balanced", sfr_rdata, 8'h07);

    // R11 load during second step of a call
    @(negedge clk);
    call_req = 1; call_pc = 16'hC3A9;
    @(negedge clk);
    call_req = 0; sfr_wr = 1; sfr_wdata = 8'h60;
    #1;
    chk(busy && !ram_we, "R11 step held", ram_we, 0);
    @(negedge clk);
    sfr_wr = 0;
    #1;
    chk(busy && ram_we && ram_addr == 8'h61 && ram_wdata == 8'hC3, "R11 step uses new ptr",
        ram_addr, 8'h61);
    @(negedge clk);
    sp_m = 8'h61; mem_m[8'h61] = 8'hC3;
    chk(!busy && sfr_rdata == 8'h61, "R11 ptr after held call", sfr_rdata, 8'h61);
    do_pop();

    finish_run();
  end
endmodule